// File: doc/BRIEF.md
# 2B1Q Symbol and Tuning Word Serializer

This block sits on the host side of a line interface and runs on a clock of 48 ticks per symbol period. On each symbol-rate tick it captures a transmit-enable flag, a 2-bit 2B1Q symbol request and an 8-bit oscillator tuning level. From these it builds two 16-bit words, one per channel.

Each word is shifted out most significant bit first on its own serial clock and data pair. When the 16th bit has been clocked, the channel's strobe drops low for a short pulse and then returns high. The rising strobe edge tells the receiving side to latch the word.

Both channels share one timing sequencer, so their clocks and strobes move together. The symbol word carries the enable and the symbol in its top three bits. The tuning word carries an inverted-offset DAC code in its top eight bits. Every unused trailing bit is driven as 0.

Top module: `sym_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, both serial clocks are low, both data lines are low, both strobes are high and busy_o is low.
- R2: A tick seen while idle starts one frame. Each channel gives exactly 16 serial clock rising edges, MSB first. The data line changes only while the serial clock is low. With HALF_TICKS=1, bit k (k=0 for the MSB) is valid from cycle 2k after acceptance, and its rising edge comes at cycle 2k+1.
- R3: Symbol word bit 15 carries tx_en_i. When tx_en_i is 1, bits 14:13 carry sym_i, coded 11 = +3, 10 = +1, 01 = -1, 00 = -3.
- R4: When tx_en_i is 0, bits 15:13 of the symbol word are all 0 (zero symbol), whatever sym_i holds.
- R5: Bits 12:0 of the symbol word and bits 7:0 of the tuning word are always 0.
- R6: Tuning word bits 15:8 equal 127 minus tune_lvl_i, modulo 256, where tune_lvl_i = 0 is the lowest output. Level 255 gives code 0x80 (highest output), level 127 gives 0x00 (mid scale) and level 0 gives 0x7F (lowest output).
- R7: Each strobe falls only after the 16th rising edge of its serial clock. It stays low for STB_TICKS cycles and is back high before the first rising edge of the next frame.
- R8: busy_o is high from the cycle after a tick is accepted until the strobe returns high.
- R9: A tick while busy is ignored. Input changes made during a frame do not alter the frame in flight.
- R10: The serial clocks of the two channels are identical in every cycle, and so are their strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 48 ticks per symbol |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_tick_i | input | 1 | Symbol-rate start pulse |
| tx_en_i | input | 1 | Transmit enable for the symbol word |
| sym_i | input | 2 | 2B1Q symbol request |
| tune_lvl_i | input | 8 | Oscillator tuning level, 0 = lowest |
| sym_sclk_o | output | 1 | Symbol channel serial clock |
| sym_sdata_o | output | 1 | Symbol channel serial data |
| sym_strobe_o | output | 1 | Symbol channel baud/latch strobe |
| tune_sclk_o | output | 1 | Tuning channel serial clock |
| tune_sdata_o | output | 1 | Tuning channel serial data |
| tune_strobe_o | output | 1 | Tuning channel latch strobe |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench sends all four enabled symbols and two disabled requests carrying nonzero symbol bits. A design that ignored the enable would leak ±1 or ±3 into a frame that should carry a zero symbol. Tuning levels 0, 127 and 255 pin down the inverted-offset mapping, where a plain binary or sign-flipped code would miss one of the three anchor points. A second tick and new input values arrive in the middle of a frame. A design that restarted, or that read its inputs live, would show an extra strobe or a corrupted word. A cycle model also checks the strobe against the 16th rising edge and the idle levels, which catches an early strobe or a missing bit.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SHIFT  = 2'd1,
    SEQ_STROBE = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CH_SYM  = 0;
  localparam int unsigned CH_TUNE = 1;
endpackage

// File: rtl/sft_word_pack.sv
module sft_word_pack #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned TUNE_W = 8
) (
  input  logic              tx_en_i,
  input  logic [1:0]        sym_i,
  input  logic [TUNE_W-1:0] tune_lvl_i,
  output logic [WORD_W-1:0] sym_word_o,
  output logic [WORD_W-1:0] tune_word_o
);
  always_comb begin
    sym_word_o = '0;
    sym_word_o[WORD_W-1] = tx_en_i;
    if (tx_en_i) sym_word_o[WORD_W-2 -: 2] = sym_i;
  end

  // inverted-offset code: top level -> 0x80, lowest -> 0x7F
  always_comb begin
    tune_word_o = '0;
    tune_word_o[WORD_W-1 -: TUNE_W] = {tune_lvl_i[TUNE_W-1], ~tune_lvl_i[TUNE_W-2:0]};
  end
endmodule

// File: rtl/sft_seq.sv
module sft_seq
  import sft_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned HALF_TICKS = 1,
  parameter int unsigned STB_TICKS  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic load_o,
  output logic adv_o,
  output logic sclk_o,
  output logic strobe_o,
  output logic busy_o
);
  localparam int unsigned HALF_W = $clog2(HALF_TICKS + 1);
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned STB_W  = $clog2(STB_TICKS + 1);

  seq_state_e       state_q;
  logic [HALF_W-1:0] half_cnt_q;
  logic [BIT_W-1:0]  bit_idx_q;
  logic [STB_W-1:0]  stb_cnt_q;
  logic              sclk_q, strobe_q;
  logic              half_done, last_bit;

  assign half_done = (half_cnt_q == HALF_W'(HALF_TICKS - 1));
  assign last_bit  = (bit_idx_q == BIT_W'(WORD_W - 1));
  assign load_o    = (state_q == SEQ_IDLE) && tick_i;
  assign adv_o     = (state_q == SEQ_SHIFT) && half_done && sclk_q;
  assign sclk_o    = sclk_q;
  assign strobe_o  = strobe_q;
  assign busy_o    = (state_q != SEQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      half_cnt_q <= '0;
      bit_idx_q  <= '0;
      stb_cnt_q  <= '0;
      sclk_q     <= 1'b0;
      strobe_q   <= 1'b1;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (tick_i) begin
            state_q    <= SEQ_SHIFT;
            half_cnt_q <= '0;
            bit_idx_q  <= '0;
            sclk_q     <= 1'b0;
          end
        end
        SEQ_SHIFT: begin
          if (half_done) begin
            half_cnt_q <= '0;
            sclk_q     <= ~sclk_q;
            if (sclk_q) begin
              if (last_bit) begin
                state_q   <= SEQ_STROBE;
                strobe_q  <= 1'b0;
                stb_cnt_q <= '0;
              end else begin
                bit_idx_q <= bit_idx_q + 1'b1;
              end
            end
          end else begin
            half_cnt_q <= half_cnt_q + 1'b1;
          end
        end
        SEQ_STROBE: begin
          if (stb_cnt_q == STB_W'(STB_TICKS - 1)) begin
            strobe_q <= 1'b1;
            state_q  <= SEQ_IDLE;
          end else begin
            stb_cnt_q <= stb_cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // rising-edge count per frame, for the strobe ordering check
  logic [BIT_W:0] rise_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_cnt_q <= '0;
    else if (load_o) rise_cnt_q <= '0;
    else if (state_q == SEQ_SHIFT && half_done && !sclk_q) rise_cnt_q <= rise_cnt_q + 1'b1;
  end

  assert_strobe_after_last_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q) |-> rise_cnt_q == (BIT_W+1)'(WORD_W));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) |-> (strobe_q && !sclk_q));

  assert_sclk_low_in_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_q |-> !sclk_q);
endmodule

// File: rtl/sft_shreg.sv
module sft_shreg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              adv_i,
  output logic              sdata_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= word_i;
    else if (adv_i)  sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign sdata_o = sh_q[WORD_W-1];
endmodule

// File: rtl/sym_frame_tx.sv
module sym_frame_tx
  import sft_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned TUNE_W     = 8,
  parameter int unsigned HALF_TICKS = 1,
  parameter int unsigned STB_TICKS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_tick_i,
  input  logic              tx_en_i,
  input  logic [1:0]        sym_i,
  input  logic [TUNE_W-1:0] tune_lvl_i,
  output logic              sym_sclk_o,
  output logic              sym_sdata_o,
  output logic              sym_strobe_o,
  output logic              tune_sclk_o,
  output logic              tune_sdata_o,
  output logic              tune_strobe_o,
  output logic              busy_o
);
  logic [WORD_W-1:0] words [NUM_CH];
  logic [NUM_CH-1:0] sdata;
  logic load, adv, sclk, strobe;

  sft_word_pack #(.WORD_W(WORD_W), .TUNE_W(TUNE_W)) u_pack (
    .tx_en_i    (tx_en_i),
    .sym_i      (sym_i),
    .tune_lvl_i (tune_lvl_i),
    .sym_word_o (words[CH_SYM]),
    .tune_word_o(words[CH_TUNE])
  );

  sft_seq #(.WORD_W(WORD_W), .HALF_TICKS(HALF_TICKS), .STB_TICKS(STB_TICKS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sym_tick_i),
    .load_o  (load),
    .adv_o   (adv),
    .sclk_o  (sclk),
    .strobe_o(strobe),
    .busy_o  (busy_o)
  );

  // shift registers double as the frame-hold registers
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    sft_shreg #(.WORD_W(WORD_W)) u_sh (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .word_i (words[ch]),
      .adv_i  (adv),
      .sdata_o(sdata[ch])
    );
  end

  assign sym_sclk_o    = sclk;
  assign tune_sclk_o   = sclk;
  assign sym_strobe_o  = strobe;
  assign tune_strobe_o = strobe;
  assign sym_sdata_o   = sdata[CH_SYM];
  assign tune_sdata_o  = sdata[CH_TUNE];

  assert_data_stable_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_sclk_o && $past(sym_sclk_o)) |-> ($stable(sym_sdata_o) && $stable(tune_sdata_o)));

  assert_idle_data_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sym_sdata_o && !tune_sdata_o));
endmodule

// File: tb/sym_frame_tx_bench.sv
module sym_frame_tx_bench;
  localparam int H     = 1;
  localparam int S     = 2;
  localparam int NBITS = 16;
  localparam int FRAME = 2*NBITS*H + S;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, tx_en = 1'b0;
  logic [1:0] sym = 2'b00;
  logic [7:0] lvl = 8'h00;
  logic s_sclk, s_sdata, s_stb, t_sclk, t_sdata, t_stb, busy;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sym_frame_tx u_sym_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .sym_tick_i(tick), .tx_en_i(tx_en), .sym_i(sym),
    .tune_lvl_i(lvl), .sym_sclk_o(s_sclk), .sym_sdata_o(s_sdata), .sym_strobe_o(s_stb),
    .tune_sclk_o(t_sclk), .tune_sdata_o(t_sdata), .tune_strobe_o(t_stb), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_sym_word(input logic en, input logic [1:0] s);
    return en ? {1'b1, s, 13'b0} : 16'h0000;
  endfunction
  function automatic logic [15:0] exp_tune_word(input logic [7:0] l);
    logic [7:0] c;
    c = 8'd127 - l;
    return {c, 8'h00};
  endfunction

  // behavioural reference: frame position since acceptance
  int pos = -1;
  logic [15:0] m_sym, m_tune;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos = -1;
    else if (pos == -1) begin
      if (tick) begin
        pos = 0;
        m_sym = exp_sym_word(tx_en, sym);
        m_tune = exp_tune_word(lvl);
      end
    end else begin
      pos++;
      if (pos == FRAME) pos = -1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_sclk, e_stb, e_busy, e_sd, e_td;
      int b;
      e_busy = (pos >= 0);
      e_sclk = (pos >= 0) && (pos < 2*NBITS*H) && ((pos % (2*H)) >= H);
      e_stb  = !((pos >= 2*NBITS*H) && (pos < FRAME));
      if (pos >= 0 && pos < 2*NBITS*H) begin
        b = pos / (2*H);
        e_sd = m_sym[15-b];
        e_td = m_tune[15-b];
      end else begin
        e_sd = 1'b0;
        e_td = 1'b0;
      end
      chk(s_sclk === e_sclk, "R2 sym sclk", 32'(s_sclk), 32'(e_sclk));
      chk(t_sclk === s_sclk, "R10 tune sclk", 32'(t_sclk), 32'(s_sclk));
      chk(s_stb === e_stb, "R7 sym strobe", 32'(s_stb), 32'(e_stb));
      chk(t_stb === s_stb, "R10 tune strobe", 32'(t_stb), 32'(s_stb));
      chk(busy === e_busy, "R8 busy", 32'(busy), 32'(e_busy));
      chk(s_sdata === e_sd, "R3 sym data", 32'(s_sdata), 32'(e_sd));
      chk(t_sdata === e_td, "R6 tune data", 32'(t_sdata), 32'(e_td));
    end
  end

  // independent deserializer on the serial pins
  logic [15:0] cap_s = '0, cap_t = '0, want_s = '0, want_t = '0;
  int rises = 0, strobe_rises = 0;
  bit armed = 1'b0;
  string cur_tag = "";
  always @(posedge s_sclk) begin
    cap_s = {cap_s[14:0], s_sdata};
    cap_t = {cap_t[14:0], t_sdata};
    rises++;
  end
  always @(posedge s_stb) begin
    if (armed && rst_n) begin
      strobe_rises++;
      chk(rises == NBITS, {cur_tag, " R2 rise count"}, 32'(rises), 32'(NBITS));
      chk(cap_s === want_s, {cur_tag, " sym word"}, 32'(cap_s), 32'(want_s));
      chk(cap_t === want_t, {cur_tag, " R6 tune word"}, 32'(cap_t), 32'(want_t));
      rises = 0;
    end
  end

  task automatic send(input logic en, input logic [1:0] s, input logic [7:0] l, input string tag,
                      input bit glitch);
    @(negedge clk);
    tx_en = en; sym = s; lvl = l; tick = 1'b1;
    want_s = exp_sym_word(en, s); want_t = exp_tune_word(l);
    cur_tag = tag; armed = 1'b1; rises = 0;
    @(negedge clk);
    tick = 1'b0;
    if (glitch) begin
      repeat (9) @(negedge clk);
      tx_en = ~en; sym = ~s; lvl = ~l; tick = 1'b1;  // R9: ignored mid-frame
      @(negedge clk);
      tick = 1'b0;
      repeat (36) @(negedge clk);
    end else begin
      repeat (46) @(negedge clk);
    end
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk(s_sclk === 1'b0 && t_sclk === 1'b0, "R1 reset sclk", 32'(s_sclk), 0);
    chk(s_stb === 1'b1 && t_stb === 1'b1, "R1 reset strobe", 32'(s_stb), 1);
    chk(s_sdata === 1'b0 && t_sdata === 1'b0 && busy === 1'b0, "R1 reset data/busy", 32'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(1'b1, 2'b11, 8'hFF, "R3 +3 lvl255", 1'b0);
    send(1'b1, 2'b10, 8'h7F, "R3 +1 lvl127", 1'b0);
    send(1'b1, 2'b01, 8'h00, "R3 -1 lvl0", 1'b0);
    send(1'b1, 2'b00, 8'h5A, "R3 -3 R5", 1'b0);
    send(1'b0, 2'b11, 8'hC8, "R4 off sym11", 1'b0);
    send(1'b0, 2'b01, 8'h80, "R4 off sym01", 1'b0);
    send(1'b1, 2'b10, 8'h33, "R9 glitch", 1'b1);
    chk(busy === 1'b0, "R9 no restart busy", 32'(busy), 0);
    chk(strobe_rises == 7, "R9 frame count", 32'(strobe_rises), 7);
    repeat (50) @(negedge clk);
    chk(strobe_rises == 7 && s_stb === 1'b1, "R1 idle stays quiet", 32'(strobe_rises), 7);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule